// File: doc/BRIEF.md
# Edge/Level Interrupt Request and EOI Engine

This block holds the per-pin request state of an interrupt router that is driven by a redirection table. Each pin has its own entry, supplied on input ports: vector, destination, delivery mode, destination mode, trigger mode and mask. The block receives line updates for each pin as a strobe together with a level. It keeps a request bit (IRR) for every pin, a mark for edge pins that have been delivered, and a remote-IRR bit for every level pin. Pins that become ready are turned into delivery requests. These leave the block one at a time over a valid/ready handshake. At the handshake the receiving side answers whether at least one target took the interrupt.

End-of-interrupt broadcasts carry a vector, a trigger mode and a directed flag. A level-mode broadcast that is not directed releases every level pin whose vector matches. If such a pin is unmasked and still requesting, it is delivered again. A per-pin counter tracks how many of these EOI redeliveries have happened back to back. When the count reaches its limit, the redelivery is held back by a timer. When the timer expires, every level pin that is requesting and released is serviced again.

Top module: `irq_eoi_engine`

## Requirements
- R1: After reset, IRR, remote-IRR, the delivered-edge marks and the coalesced flags are all zero, and `dlv_valid` is low.
- R2: A high line strobe on an unmasked edge pin (`ent_level`=0) whose IRR is clear sets IRR and produces exactly one delivery carrying that pin's vector. When that delivery is handed over, the pin's delivered-edge mark is set.
- R3: A high strobe on an edge pin whose IRR is already set raises the pin's `coalesced_o` bit in the next cycle and produces no delivery. It also clears the pin's delivered-edge mark. A low strobe clears IRR.
- R4: A masked pin (`ent_mask`=1) never produces a delivery, although its IRR still follows its line.
- R5: When a delivery from a level pin (`ent_level`=1) is handed over with `dlv_accept`=1, the pin's remote-IRR bit is set. A high strobe on that pin while remote-IRR is set is reported as coalesced and delivers nothing.
- R6: A broadcast with `eoi_level`=1 and `eoi_directed`=0 clears remote-IRR on every level pin whose vector matches. A matching pin that is unmasked and still has IRR set is delivered again.
- R7: A broadcast with `eoi_level`=0, or with `eoi_directed`=1, leaves remote-IRR unchanged and causes no delivery.
- R8: A level delivery handed over with `dlv_accept`=0 leaves remote-IRR clear.
- R9: Each pin counts its back-to-back EOI redeliveries. The EOI that would make the count reach STORM_LIMIT resets the count and delivers nothing at once. Instead the delay timer starts, and exactly DEFER_CYCLES cycles after the edge on which that EOI was sampled, every level pin with IRR set and remote-IRR clear is serviced.
- R10: An EOI that finds its pin masked or with IRR clear resets that pin's redelivery count to zero.
- R11: When several pins are ready at the same time, the lowest-numbered pin is offered first. A request that has been offered stays valid until `dlv_ready` takes it.
- R12: Reset cancels a pending delayed redelivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_stb | input | NPINS | Per-pin line update strobe |
| line_lvl | input | NPINS | Level applied by the strobe |
| ent_vector | input | NPINS*VW | Vector of each entry |
| ent_dest | input | NPINS*DW | Destination of each entry |
| ent_dmode | input | NPINS*3 | Delivery mode of each entry |
| ent_logical | input | NPINS | Destination mode of each entry (1 = logical) |
| ent_level | input | NPINS | Trigger mode of each entry (1 = level, 0 = edge) |
| ent_mask | input | NPINS | Mask of each entry |
| eoi_valid | input | 1 | EOI broadcast strobe |
| eoi_vector | input | VW | Vector being acknowledged |
| eoi_level | input | 1 | Trigger mode of the EOI (1 = level) |
| eoi_directed | input | 1 | EOI flagged as directed; it releases nothing |
| dlv_valid | output | 1 | Delivery request valid |
| dlv_ready | input | 1 | Delivery request taken |
| dlv_accept | input | 1 | At the handshake, at least one target accepted |
| dlv_pin | output | PW | Pin number of the request |
| dlv_vector | output | VW | Vector of the request |
| dlv_dest | output | DW | Destination of the request |
| dlv_dmode | output | 3 | Delivery mode of the request |
| dlv_logical | output | 1 | Destination mode of the request |
| dlv_level | output | 1 | Trigger mode of the request |
| irr_o | output | NPINS | Request register |
| remote_irr_o | output | NPINS | Remote-IRR bits |
| edge_done_o | output | NPINS | Delivered-edge marks |
| coalesced_o | output | NPINS | One-cycle flag for a line assertion that was coalesced |

## Verification
Strobes and broadcasts are sampled on the clock edge where they are applied. IRR, remote-IRR, the coalesced flag and a new `dlv_valid` therefore appear in the cycle right after that edge. The delivered-edge mark and a remote-IRR set by acceptance appear one cycle after the handshake edge. A deferred redelivery becomes valid exactly DEFER_CYCLES edges after the tripping EOI was sampled. The bench checks this one cycle early (still low) and on the cycle it is due (high). A scoreboard queue gets the expected pin before each stimulus. A negedge monitor pops and compares the queue at every handshake, and after a settle window of a few cycles an empty queue is required. This catches missing, extra, early and misordered deliveries.

// File: rtl/irq_eoi_pkg.sv
package irq_eoi_pkg;
  // an assertion is coalesced when the pin's holding bit is already set:
  // IRR for edge pins, remote-IRR for level pins
  function automatic logic is_coalesced(input logic lvl_mode, input logic irr_q,
                                        input logic rirr_q);
    return lvl_mode ? rirr_q : irr_q;
  endfunction

  // true when one more redelivery reaches the storm limit
  function automatic logic storm_hit(input logic [31:0] cnt, input logic [31:0] limit);
    return (cnt + 32'd1) >= limit;
  endfunction
endpackage

// File: rtl/irq_pin_slice.sv
module irq_pin_slice #(
  parameter int STORM_LIMIT = 10000,
  localparam int CW = $clog2(STORM_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic lvl,
  input  logic ent_level,
  input  logic ent_mask,
  input  logic eoi_hit,
  input  logic grant,
  input  logic accept,
  input  logic defer_fire,
  output logic irr_q,
  output logic rirr_q,
  output logic edone_q,
  output logic pend_q,
  output logic coal_q,
  output logic storm_trip
);
  import irq_eoi_pkg::*;

  logic [CW-1:0] cnt_q;
  logic assert_hi, assert_lo, coal_now, svc_line, eoi_lvl, eoi_redo, svc_eoi, svc_defer;

  assign assert_hi  = stb & lvl;
  assign assert_lo  = stb & ~lvl;
  assign coal_now   = assert_hi & is_coalesced(ent_level, irr_q, rirr_q);
  assign svc_line   = assert_hi & ~coal_now;
  assign eoi_lvl    = eoi_hit & ent_level;
  assign eoi_redo   = eoi_lvl & ~ent_mask & irr_q;
  assign storm_trip = eoi_redo & storm_hit(32'(cnt_q), 32'(STORM_LIMIT));
  assign svc_eoi    = eoi_redo & ~storm_trip;
  assign svc_defer  = defer_fire & ent_level & irr_q & ~rirr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q   <= 1'b0;
      rirr_q  <= 1'b0;
      edone_q <= 1'b0;
      pend_q  <= 1'b0;
      coal_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      coal_q <= coal_now;
      if (assert_hi)      irr_q <= 1'b1;
      else if (assert_lo) irr_q <= 1'b0;

      if (assert_hi)                 edone_q <= 1'b0;
      else if (grant && !ent_level)  edone_q <= 1'b1;

      if (grant && accept && ent_level) rirr_q <= 1'b1;
      else if (eoi_lvl)                 rirr_q <= 1'b0;

      if (ent_mask)                              pend_q <= 1'b0;
      else if (svc_line || svc_eoi || svc_defer) pend_q <= 1'b1;
      else if (grant)                            pend_q <= 1'b0;

      if (eoi_lvl) cnt_q <= (eoi_redo && !storm_trip) ? CW'(cnt_q + 1'b1) : '0;
    end
  end
endmodule

// File: rtl/irq_lowest_arb.sv
module irq_lowest_arb #(
  parameter int N = 8,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [PW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        gnt[i] = 1'b1;
        idx    = PW'(i);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_defer_timer.sv
module irq_defer_timer #(
  parameter int DEFER_CYCLES = 1000,
  localparam int TW = $clog2(DEFER_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic fire
);
  logic [TW-1:0] cnt_q;

  assign busy = (cnt_q != '0);
  assign fire = (cnt_q == TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (start && !busy)  cnt_q <= TW'(DEFER_CYCLES);
    else if (busy)            cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/irq_eoi_engine.sv
module irq_eoi_engine #(
  parameter int NPINS        = 8,
  parameter int VW           = 8,
  parameter int DW           = 8,
  parameter int STORM_LIMIT  = 10000,
  parameter int DEFER_CYCLES = 1000,
  localparam int PW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   line_stb,
  input  logic [NPINS-1:0]   line_lvl,
  input  logic [NPINS*VW-1:0] ent_vector,
  input  logic [NPINS*DW-1:0] ent_dest,
  input  logic [NPINS*3-1:0] ent_dmode,
  input  logic [NPINS-1:0]   ent_logical,
  input  logic [NPINS-1:0]   ent_level,
  input  logic [NPINS-1:0]   ent_mask,
  input  logic               eoi_valid,
  input  logic [VW-1:0]      eoi_vector,
  input  logic               eoi_level,
  input  logic               eoi_directed,
  output logic               dlv_valid,
  input  logic               dlv_ready,
  input  logic               dlv_accept,
  output logic [PW-1:0]      dlv_pin,
  output logic [VW-1:0]      dlv_vector,
  output logic [DW-1:0]      dlv_dest,
  output logic [2:0]         dlv_dmode,
  output logic               dlv_logical,
  output logic               dlv_level,
  output logic [NPINS-1:0]   irr_o,
  output logic [NPINS-1:0]   remote_irr_o,
  output logic [NPINS-1:0]   edge_done_o,
  output logic [NPINS-1:0]   coalesced_o
);
  logic [NPINS-1:0] pend, ready_req, grant_vec, pin_grant, eoi_hit, trip;
  logic             storm_trip_any, defer_busy, defer_fire, handshake;

  assign ready_req      = pend & ~ent_mask;
  assign handshake      = dlv_valid & dlv_ready;
  assign pin_grant      = grant_vec & {NPINS{handshake}};
  assign storm_trip_any = |trip;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign eoi_hit[i] = eoi_valid & eoi_level & ~eoi_directed &
                        (ent_vector[i*VW +: VW] == eoi_vector);
    irq_pin_slice #(.STORM_LIMIT(STORM_LIMIT)) u_slice (
      .clk        (clk),
      .rst_n      (rst_n),
      .stb        (line_stb[i]),
      .lvl        (line_lvl[i]),
      .ent_level  (ent_level[i]),
      .ent_mask   (ent_mask[i]),
      .eoi_hit    (eoi_hit[i]),
      .grant      (pin_grant[i]),
      .accept     (dlv_accept),
      .defer_fire (defer_fire),
      .irr_q      (irr_o[i]),
      .rirr_q     (remote_irr_o[i]),
      .edone_q    (edge_done_o[i]),
      .pend_q     (pend[i]),
      .coal_q     (coalesced_o[i]),
      .storm_trip (trip[i])
    );
  end

  irq_lowest_arb #(.N(NPINS)) u_arb (
    .req (ready_req),
    .gnt (grant_vec),
    .idx (dlv_pin),
    .any (dlv_valid)
  );

  irq_defer_timer #(.DEFER_CYCLES(DEFER_CYCLES)) u_defer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (storm_trip_any),
    .busy  (defer_busy),
    .fire  (defer_fire)
  );

  assign dlv_vector  = ent_vector[dlv_pin*VW +: VW];
  assign dlv_dest    = ent_dest[dlv_pin*DW +: DW];
  assign dlv_dmode   = ent_dmode[dlv_pin*3 +: 3];
  assign dlv_logical = ent_logical[dlv_pin];
  assign dlv_level   = ent_level[dlv_pin];
endmodule

// File: rtl/irq_eoi_engine_chk.sv
module irq_eoi_engine_chk #(
  parameter int NPINS = 8,
  localparam int PW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] line_stb,
  input logic [NPINS-1:0] line_lvl,
  input logic [NPINS-1:0] ent_level,
  input logic [NPINS-1:0] ent_mask,
  input logic             dlv_valid,
  input logic             dlv_ready,
  input logic             dlv_accept,
  input logic [PW-1:0]    dlv_pin,
  input logic             dlv_level,
  input logic [NPINS-1:0] irr_o,
  input logic [NPINS-1:0] remote_irr_o,
  input logic [NPINS-1:0] edge_done_o,
  input logic [NPINS-1:0] coalesced_o,
  input logic [NPINS-1:0] grant_vec,
  input logic [NPINS-1:0] eoi_hit,
  input logic [NPINS-1:0] pin_grant,
  input logic             storm_trip_any,
  input logic             defer_busy
);
  p_masked_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> !ent_mask[dlv_pin]);

  p_edge_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_ready && !dlv_level) |=> edge_done_o[$past(dlv_pin)]);

  p_remote_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_ready && dlv_accept && dlv_level) |=> remote_irr_o[$past(dlv_pin)]);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && !dlv_ready) |=> (dlv_valid || !$stable(ent_mask)));

  p_one_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  p_defer_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (storm_trip_any && !defer_busy) |=> defer_busy);

  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    p_edge_coal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (line_stb[i] && line_lvl[i] && !ent_level[i] && irr_o[i]) |=> coalesced_o[i]);

    p_eoi_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_hit[i] && ent_level[i] && !(pin_grant[i] && dlv_accept)) |=> !remote_irr_o[i]);
  end
endmodule

bind irq_eoi_engine irq_eoi_engine_chk #(.NPINS(NPINS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .line_stb       (line_stb),
  .line_lvl       (line_lvl),
  .ent_level      (ent_level),
  .ent_mask       (ent_mask),
  .dlv_valid      (dlv_valid),
  .dlv_ready      (dlv_ready),
  .dlv_accept     (dlv_accept),
  .dlv_pin        (dlv_pin),
  .dlv_level      (dlv_level),
  .irr_o          (irr_o),
  .remote_irr_o   (remote_irr_o),
  .edge_done_o    (edge_done_o),
  .coalesced_o    (coalesced_o),
  .grant_vec      (grant_vec),
  .eoi_hit        (eoi_hit),
  .pin_grant      (pin_grant),
  .storm_trip_any (storm_trip_any),
  .defer_busy     (defer_busy)
);

// File: tb/irq_eoi_engine_tb_top.sv
module irq_eoi_engine_tb_top;
  localparam int N  = 4;
  localparam int VW = 8;
  localparam int DW = 8;
  localparam int LIM = 3;
  localparam int DEF = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] line_stb = '0, line_lvl = '0;
  logic [N*VW-1:0] ent_vector;
  logic [N*DW-1:0] ent_dest;
  logic [N*3-1:0]  ent_dmode;
  logic [N-1:0] ent_logical, ent_level, ent_mask;
  logic eoi_valid = 1'b0, eoi_level = 1'b0, eoi_directed = 1'b0;
  logic [VW-1:0] eoi_vector = '0;
  logic dlv_valid, dlv_ready = 1'b1, dlv_accept = 1'b1;
  logic [1:0] dlv_pin;
  logic [VW-1:0] dlv_vector;
  logic [DW-1:0] dlv_dest;
  logic [2:0] dlv_dmode;
  logic dlv_logical, dlv_level;
  logic [N-1:0] irr_o, remote_irr_o, edge_done_o, coalesced_o;

  int n_checks = 0, n_fail = 0;
  string cur_req = "R1";
  int expq[$];

  always #2 clk = ~clk;

  // pin0 edge, pin1 level, pin2 level, pin3 edge but masked
  initial begin
    for (int i = 0; i < N; i++) begin
      ent_vector[i*VW +: VW] = VW'(8'h40 + i);
      ent_dest[i*DW +: DW]   = DW'(8'h10 + i);
      ent_dmode[i*3 +: 3]    = 3'(i);
    end
    ent_logical = 4'b0101;
    ent_level   = 4'b0110;
    ent_mask    = 4'b1000;
  end

  irq_eoi_engine #(.NPINS(N), .VW(VW), .DW(DW), .STORM_LIMIT(LIM), .DEFER_CYCLES(DEF)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .line_lvl(line_lvl),
    .ent_vector(ent_vector), .ent_dest(ent_dest), .ent_dmode(ent_dmode),
    .ent_logical(ent_logical), .ent_level(ent_level), .ent_mask(ent_mask),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_level(eoi_level),
    .eoi_directed(eoi_directed), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
    .dlv_accept(dlv_accept), .dlv_pin(dlv_pin), .dlv_vector(dlv_vector),
    .dlv_dest(dlv_dest), .dlv_dmode(dlv_dmode), .dlv_logical(dlv_logical),
    .dlv_level(dlv_level), .irr_o(irr_o), .remote_irr_o(remote_irr_o),
    .edge_done_o(edge_done_o), .coalesced_o(coalesced_o));

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pop the scoreboard at every handshake
  always @(negedge clk) begin
    if (rst_n && dlv_valid && dlv_ready) begin
      if (expq.size() == 0) begin
        check(cur_req, "unexpected delivery from pin", int'(dlv_pin), -1);
      end else begin
        automatic int e = expq.pop_front();
        check(cur_req, "delivered pin", int'(dlv_pin), e);
        check(cur_req, "delivered vector", int'(dlv_vector), 8'h40 + e);
        check(cur_req, "delivered dest", int'(dlv_dest), 8'h10 + e);
        check(cur_req, "delivered trigger", int'(dlv_level), (e == 1 || e == 2) ? 1 : 0);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic strobe(input int pin, input logic lvl);
    line_stb[pin] = 1'b1;
    line_lvl[pin] = lvl;
    tick();
    line_stb[pin] = 1'b0;
  endtask

  task automatic eoi(input int vec, input logic lvl, input logic dir);
    eoi_valid = 1'b1; eoi_vector = VW'(vec); eoi_level = lvl; eoi_directed = dir;
    tick();
    eoi_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (4) tick();
    check(cur_req, "missing deliveries", expq.size(), 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1
    cur_req = "R1";
    check("R1", "irr", int'(irr_o), 0);
    check("R1", "remote", int'(remote_irr_o), 0);
    check("R1", "edge_done", int'(edge_done_o), 0);
    check("R1", "coalesced", int'(coalesced_o), 0);
    check("R1", "dlv_valid", int'(dlv_valid), 0);
    // R2 edge delivery
    cur_req = "R2";
    expq.push_back(0);
    strobe(0, 1'b1);
    check("R2", "valid after strobe", int'(dlv_valid), 1);
    settle();
    check("R2", "edge_done[0]", int'(edge_done_o[0]), 1);
    check("R2", "irr[0]", int'(irr_o[0]), 1);
    // R3 coalesced edge, then low clears irr
    cur_req = "R3";
    strobe(0, 1'b1);
    check("R3", "coalesced[0]", int'(coalesced_o[0]), 1);
    settle();
    check("R3", "edge_done[0] cleared", int'(edge_done_o[0]), 0);
    strobe(0, 1'b0);
    check("R3", "irr[0] low", int'(irr_o[0]), 0);
    // R4 masked pin
    cur_req = "R4";
    strobe(3, 1'b1);
    settle();
    check("R4", "irr[3]", int'(irr_o[3]), 1);
    check("R4", "valid", int'(dlv_valid), 0);
    // R5 level delivery sets remote, then coalesces
    cur_req = "R5";
    expq.push_back(1);
    strobe(1, 1'b1);
    settle();
    check("R5", "remote[1]", int'(remote_irr_o[1]), 1);
    strobe(1, 1'b1);
    check("R5", "coalesced[1]", int'(coalesced_o[1]), 1);
    settle();
    // R7 edge or directed EOI ignored
    cur_req = "R7";
    eoi(8'h41, 1'b0, 1'b0);
    settle();
    check("R7", "remote[1] after edge eoi", int'(remote_irr_o[1]), 1);
    eoi(8'h41, 1'b1, 1'b1);
    settle();
    check("R7", "remote[1] after directed eoi", int'(remote_irr_o[1]), 1);
    // R6 level EOI releases and redelivers
    cur_req = "R6";
    expq.push_back(1);
    eoi(8'h41, 1'b1, 1'b0);
    check("R6", "remote[1] released", int'(remote_irr_o[1]), 0);
    settle();
    check("R6", "remote[1] set again", int'(remote_irr_o[1]), 1);
    // R8 unaccepted level delivery
    cur_req = "R8";
    strobe(1, 1'b0);
    eoi(8'h41, 1'b1, 1'b0);
    settle();
    dlv_accept = 1'b0;
    expq.push_back(1);
    strobe(1, 1'b1);
    settle();
    check("R8", "remote[1] stays clear", int'(remote_irr_o[1]), 0);
    dlv_accept = 1'b1;
    strobe(1, 1'b0);
    // R9 storm deferral on pin2
    cur_req = "R9";
    expq.push_back(2);
    strobe(2, 1'b1);
    settle();
    for (int k = 0; k < LIM - 1; k++) begin
      expq.push_back(2);
      eoi(8'h42, 1'b1, 1'b0);
      settle();
    end
    eoi(8'h42, 1'b1, 1'b0);
    repeat (DEF - 1) tick();
    check("R9", "valid one cycle before due", int'(dlv_valid), 0);
    expq.push_back(2);
    tick();
    check("R9", "valid when due", int'(dlv_valid), 1);
    settle();
    // R10 counter cleared when EOI finds irr clear
    cur_req = "R10";
    for (int k = 0; k < LIM - 1; k++) begin
      expq.push_back(2);
      eoi(8'h42, 1'b1, 1'b0);
      settle();
    end
    strobe(2, 1'b0);
    eoi(8'h42, 1'b1, 1'b0);
    settle();
    expq.push_back(2);
    strobe(2, 1'b1);
    settle();
    expq.push_back(2);
    eoi(8'h42, 1'b1, 1'b0);
    settle();
    // R11 lowest pin first, held while not ready
    cur_req = "R11";
    dlv_ready = 1'b0;
    line_stb = 4'b0011; line_lvl = 4'b0011;
    tick();
    line_stb = '0;
    tick(); tick();
    check("R11", "valid held", int'(dlv_valid), 1);
    check("R11", "offered pin", int'(dlv_pin), 0);
    expq.push_back(0);
    expq.push_back(1);
    dlv_ready = 1'b1;
    settle();
    strobe(0, 1'b0);
    strobe(1, 1'b0);
    // R12 reset cancels deferred redelivery
    cur_req = "R12";
    expq.push_back(2);
    eoi(8'h42, 1'b1, 1'b0);
    settle();
    eoi(8'h42, 1'b1, 1'b0);
    repeat (3) tick();
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    dlv_accept = 1'b0;
    expq.push_back(2);
    strobe(2, 1'b1);
    settle();
    repeat (DEF + 5) tick();
    check("R12", "no late delivery", expq.size(), 0);
    check("R12", "valid low", int'(dlv_valid), 0);
    dlv_accept = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog %s: actual timeout expected completion", cur_req);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule